// File: doc/BRIEF.md
# AXI4 Burst Slave Memory

This block is an AXI4 slave that answers bursts from one on-chip master out of a private byte-addressable store. By default the store holds 4 KB, kept as 32-bit words with a write enable per byte lane. It has all five channels: write address, write data, write response, read address and read data. It uses 32-bit addresses and data and 4-bit transaction IDs. Two independent state machines share the store, one for writes and one for reads. A read burst can therefore run while a write burst is still collecting data.

The write machine has three states. `WR_IDLE` takes the address handshake and moves to `WR_DATA`. `WR_DATA` takes data beats and moves to `WR_RESP` on the beat that carries WLAST. `WR_RESP` holds the response until it is accepted, then returns to `WR_IDLE`. The read machine has two states. `RD_IDLE` takes the address handshake, loads the first beat and moves to `RD_BURST`. `RD_BURST` hands out beats and returns to `RD_IDLE` after the beat that carries RLAST is accepted.

Each burst is checked once, when its address is accepted. The burst type, the start address and the transfer size are all tested then. A burst that fails this check still runs its full length, but it never touches the store and every one of its responses reports an error.

Top module: `axi_burst_mem`

## Requirements
- R1: After reset, AWREADY and ARREADY are 1, and BVALID and RVALID are 0.
- R2: A write beat updates a byte of the 32-bit word at the beat address (bits 11:2) only when that byte's WSTRB bit is set (lane 0 is bits 7:0). All other bytes keep their values.
- R3: The burst type is 2'b00 for FIXED and 2'b01 for INCR. FIXED uses the start address on every beat. INCR gets each next beat address by aligning the previous one down to 2^size bytes and then adding 2^size. A read beat returns the whole stored word at its beat address.
- R4: A read burst returns ARLEN+1 beats, and RLAST is 1 only on the final beat. RVALID drops after the final beat is accepted. BVALID stays 0 while data beats are being taken and rises in the cycle after the beat that carries WLAST is accepted.
- R5: BID equals the accepted AWID, and RID equals the accepted ARID.
- R6: The response is OKAY (2'b00) for a legal burst. It is SLVERR (2'b10) when the burst type is 2'b10 or 2'b11, when any start-address bit at or above bit 12 is set, or when the size code is above 2. A failing write burst changes no byte of the store. A failing read burst returns zero data on every beat.
- R7: Each direction takes only one burst at a time. AWREADY is 0 from the address handshake until the write response is accepted. ARREADY is 0 from the address handshake until the final read beat is accepted.
- R8: While a write burst is waiting for data, a read burst is accepted and completes. The write then finishes normally.
- R9: Address bits above bit 11 are ignored when the store is indexed. An INCR burst that starts in range and steps past the last word continues at word 0.
- R10: While VALID is high and READY is low, BVALID, BID and BRESP hold steady. Likewise RVALID, RDATA, RID, RRESP and RLAST hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awid | input | 4 | Write transaction ID |
| awaddr | input | 32 | Write start byte address |
| awlen | input | 8 | Write beats minus one |
| awsize | input | 3 | Write log2 bytes per beat |
| awburst | input | 2 | Write burst type |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte-lane enables |
| wlast | input | 1 | Final write beat marker |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bid | output | 4 | Write response ID |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| arid | input | 4 | Read transaction ID |
| araddr | input | 32 | Read start byte address |
| arlen | input | 8 | Read beats minus one |
| arsize | input | 3 | Read log2 bytes per beat |
| arburst | input | 2 | Read burst type |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rid | output | 4 | Read data ID |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response code |
| rlast | output | 1 | Final read beat marker |

## Verification
A write machine stuck in the wrong state shows up within a cycle of the next handshake. Either AWREADY stays low, or BVALID rises before WLAST or fails to rise after it. A wrong beat address or a lost error flag cannot be seen on the write side, so it shows only when a later read returns the stored bytes. The bench therefore reads back every written area and compares it with its own byte-level model, checking each beat in the cycle it is presented. A read machine with a bad beat count or address shows on the same beat, through RLAST, RDATA, or RVALID staying high one cycle too long.

// File: rtl/axi_mem_pkg.sv
package axi_mem_pkg;

    typedef enum logic [1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01,
        BURST_WRAP  = 2'b10,
        BURST_RSVD  = 2'b11
    } burst_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_DATA = 2'd1,
        WR_RESP = 2'd2
    } wr_state_e;

    typedef enum logic {
        RD_IDLE  = 1'b0,
        RD_BURST = 1'b1
    } rd_state_e;

endpackage

// File: rtl/axi_mem_addr_step.sv
module axi_mem_addr_step
    import axi_mem_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [1:0]        burst,
    input  logic [2:0]        size,
    output logic [ADDR_W-1:0] next_addr
);

    logic [ADDR_W-1:0] step_bytes;
    logic [ADDR_W-1:0] aligned;

    always_comb begin
        step_bytes = {{(ADDR_W-1){1'b0}}, 1'b1} << size;
        aligned    = cur_addr & ~(step_bytes - {{(ADDR_W-1){1'b0}}, 1'b1});
        if (burst == BURST_FIXED) begin
            next_addr = cur_addr;
        end else begin
            next_addr = aligned + step_bytes;
        end
    end

endmodule

// File: rtl/axi_mem_array.sv
module axi_mem_array #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024,
    localparam int AW     = $clog2(DEPTH),
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int lane = 0; lane < STRB_W; lane++) begin
                if (wstrb[lane]) begin
                    words[waddr][lane*8 +: 8] <= wdata[lane*8 +: 8];
                end
            end
        end
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/axi_mem_wr_fsm.sv
module axi_mem_wr_fsm
    import axi_mem_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int ID_W      = 4,
    parameter int MEM_BYTES = 4096,
    localparam int STRB_W  = DATA_W / 8,
    localparam int LANE_W  = $clog2(STRB_W),
    localparam int IDX_W   = $clog2(MEM_BYTES),
    localparam int WORD_AW = IDX_W - LANE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               awvalid,
    output logic               awready,
    input  logic [ID_W-1:0]    awid,
    input  logic [ADDR_W-1:0]  awaddr,
    input  logic [7:0]         awlen,
    input  logic [2:0]         awsize,
    input  logic [1:0]         awburst,
    input  logic               wvalid,
    output logic               wready,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [STRB_W-1:0]  wstrb,
    input  logic               wlast,
    output logic               bvalid,
    input  logic               bready,
    output logic [ID_W-1:0]    bid,
    output logic [1:0]         bresp,
    output logic               mem_we,
    output logic [WORD_AW-1:0] mem_waddr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [STRB_W-1:0]  mem_wstrb
);

    wr_state_e         state_q, state_d;
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_nxt;
    logic [1:0]        burst_q;
    logic [2:0]        size_q;
    logic              err_q;
    logic [7:0]        len_q;
    logic [7:0]        beat_q;
    logic              aw_fire, w_fire, b_fire;
    logic              req_err;

    axi_mem_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .cur_addr (addr_q),
        .burst    (burst_q),
        .size     (size_q),
        .next_addr(addr_nxt)
    );

    assign aw_fire = awvalid && awready;
    assign w_fire  = wvalid && wready;
    assign b_fire  = bvalid && bready;

    // legality is judged once, on the start address and burst attributes
    always_comb begin
        req_err = awburst[1]
               || (awaddr[ADDR_W-1:IDX_W] != '0)
               || (awsize > 3'(LANE_W));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: if (aw_fire)          state_d = WR_DATA;
            WR_DATA: if (w_fire && wlast)  state_d = WR_RESP;
            WR_RESP: if (b_fire)           state_d = WR_IDLE;
            default:                       state_d = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q    <= '0;
            addr_q  <= '0;
            burst_q <= BURST_INCR;
            size_q  <= '0;
            err_q   <= 1'b0;
            len_q   <= '0;
            beat_q  <= '0;
        end else if (aw_fire) begin
            id_q    <= awid;
            addr_q  <= awaddr;
            burst_q <= awburst;
            size_q  <= awsize;
            err_q   <= req_err;
            len_q   <= awlen;
            beat_q  <= '0;
        end else if (w_fire) begin
            addr_q  <= addr_nxt;
            beat_q  <= beat_q + 8'd1;
        end
    end

    always_comb begin
        awready   = (state_q == WR_IDLE);
        wready    = (state_q == WR_DATA);
        bvalid    = (state_q == WR_RESP);
        bid       = id_q;
        bresp     = err_q ? RESP_SLVERR : RESP_OKAY;
        mem_we    = w_fire && !err_q;
        mem_waddr = addr_q[IDX_W-1:LANE_W];
        mem_wdata = wdata;
        mem_wstrb = wstrb;
    end

    a_r7_aw_single: assert property (@(posedge clk) disable iff (!rst_n)
        aw_fire |=> !awready);

    a_r4_b_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (w_fire && wlast) |=> bvalid);

    a_r4_wlast_on_final_beat: assert property (@(posedge clk) disable iff (!rst_n)
        w_fire |-> (wlast == (beat_q == len_q)));

    a_r10_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> (bvalid && $stable(bid) && $stable(bresp)));

endmodule

// File: rtl/axi_mem_rd_fsm.sv
module axi_mem_rd_fsm
    import axi_mem_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int ID_W      = 4,
    parameter int MEM_BYTES = 4096,
    localparam int STRB_W  = DATA_W / 8,
    localparam int LANE_W  = $clog2(STRB_W),
    localparam int IDX_W   = $clog2(MEM_BYTES),
    localparam int WORD_AW = IDX_W - LANE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arvalid,
    output logic               arready,
    input  logic [ID_W-1:0]    arid,
    input  logic [ADDR_W-1:0]  araddr,
    input  logic [7:0]         arlen,
    input  logic [2:0]         arsize,
    input  logic [1:0]         arburst,
    output logic               rvalid,
    input  logic               rready,
    output logic [ID_W-1:0]    rid,
    output logic [DATA_W-1:0]  rdata,
    output logic [1:0]         rresp,
    output logic               rlast,
    output logic [WORD_AW-1:0] mem_raddr,
    input  logic [DATA_W-1:0]  mem_rdata
);

    rd_state_e         state_q, state_d;
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_nxt;
    logic [1:0]        burst_q;
    logic [2:0]        size_q;
    logic              err_q;
    logic [7:0]        cnt_q;
    logic [DATA_W-1:0] rdata_q;
    logic              ar_fire, r_fire;
    logic              req_err;

    axi_mem_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .cur_addr (addr_q),
        .burst    (burst_q),
        .size     (size_q),
        .next_addr(addr_nxt)
    );

    assign ar_fire = arvalid && arready;
    assign r_fire  = rvalid && rready;

    always_comb begin
        req_err = arburst[1]
               || (araddr[ADDR_W-1:IDX_W] != '0)
               || (arsize > 3'(LANE_W));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:  if (ar_fire)                   state_d = RD_BURST;
            RD_BURST: if (r_fire && cnt_q == 8'd0)   state_d = RD_IDLE;
            default:                                 state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // the beat word is captured into rdata_q so it cannot move under backpressure
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q    <= '0;
            addr_q  <= '0;
            burst_q <= BURST_INCR;
            size_q  <= '0;
            err_q   <= 1'b0;
            cnt_q   <= '0;
            rdata_q <= '0;
        end else if (ar_fire) begin
            id_q    <= arid;
            addr_q  <= araddr;
            burst_q <= arburst;
            size_q  <= arsize;
            err_q   <= req_err;
            cnt_q   <= arlen;
            rdata_q <= req_err ? '0 : mem_rdata;
        end else if (r_fire && cnt_q != 8'd0) begin
            addr_q  <= addr_nxt;
            cnt_q   <= cnt_q - 8'd1;
            rdata_q <= err_q ? '0 : mem_rdata;
        end
    end

    always_comb begin
        arready   = (state_q == RD_IDLE);
        rvalid    = (state_q == RD_BURST);
        rid       = id_q;
        rdata     = rdata_q;
        rresp     = err_q ? RESP_SLVERR : RESP_OKAY;
        rlast     = (state_q == RD_BURST) && (cnt_q == 8'd0);
        mem_raddr = (state_q == RD_IDLE) ? araddr[IDX_W-1:LANE_W]
                                         : addr_nxt[IDX_W-1:LANE_W];
    end

    a_r7_ar_single: assert property (@(posedge clk) disable iff (!rst_n)
        ar_fire |=> !arready);

    a_r4_r_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (r_fire && rlast) |=> !rvalid);

    a_r10_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rlast)
                                 && $stable(rid) && $stable(rresp)));

    a_r6_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && rresp == RESP_SLVERR) |-> (rdata == '0));

endmodule

// File: rtl/axi_burst_mem.sv
module axi_burst_mem
    import axi_mem_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int ID_W      = 4,
    parameter int MEM_BYTES = 4096,
    localparam int STRB_W  = DATA_W / 8,
    localparam int LANE_W  = $clog2(STRB_W),
    localparam int IDX_W   = $clog2(MEM_BYTES),
    localparam int WORD_AW = IDX_W - LANE_W,
    localparam int DEPTH   = MEM_BYTES / STRB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ID_W-1:0]   awid,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic [7:0]        awlen,
    input  logic [2:0]        awsize,
    input  logic [1:0]        awburst,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wlast,
    output logic              bvalid,
    input  logic              bready,
    output logic [ID_W-1:0]   bid,
    output logic [1:0]        bresp,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ID_W-1:0]   arid,
    input  logic [ADDR_W-1:0] araddr,
    input  logic [7:0]        arlen,
    input  logic [2:0]        arsize,
    input  logic [1:0]        arburst,
    output logic              rvalid,
    input  logic              rready,
    output logic [ID_W-1:0]   rid,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rlast
);

    logic               mem_we;
    logic [WORD_AW-1:0] mem_waddr;
    logic [DATA_W-1:0]  mem_wdata;
    logic [STRB_W-1:0]  mem_wstrb;
    logic [WORD_AW-1:0] mem_raddr;
    logic [DATA_W-1:0]  mem_rdata;

    axi_mem_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
        .clk  (clk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(mem_wdata),
        .wstrb(mem_wstrb),
        .raddr(mem_raddr),
        .rdata(mem_rdata)
    );

    axi_mem_wr_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .MEM_BYTES(MEM_BYTES)
    ) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .awvalid  (awvalid),
        .awready  (awready),
        .awid     (awid),
        .awaddr   (awaddr),
        .awlen    (awlen),
        .awsize   (awsize),
        .awburst  (awburst),
        .wvalid   (wvalid),
        .wready   (wready),
        .wdata    (wdata),
        .wstrb    (wstrb),
        .wlast    (wlast),
        .bvalid   (bvalid),
        .bready   (bready),
        .bid      (bid),
        .bresp    (bresp),
        .mem_we   (mem_we),
        .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata),
        .mem_wstrb(mem_wstrb)
    );

    axi_mem_rd_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .MEM_BYTES(MEM_BYTES)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .arvalid  (arvalid),
        .arready  (arready),
        .arid     (arid),
        .araddr   (araddr),
        .arlen    (arlen),
        .arsize   (arsize),
        .arburst  (arburst),
        .rvalid   (rvalid),
        .rready   (rready),
        .rid      (rid),
        .rdata    (rdata),
        .rresp    (rresp),
        .rlast    (rlast),
        .mem_raddr(mem_raddr),
        .mem_rdata(mem_rdata)
    );

    // R1: both address channels open and no response pending out of reset
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (awready && arready && !bvalid && !rvalid));

endmodule

// File: tb/axi_burst_mem_tb.sv
`timescale 1ns/1ps
module axi_burst_mem_tb;

    typedef struct packed {
        logic        wr;
        logic [3:0]  id;
        logic [31:0] addr;
        logic [7:0]  len;
        logic [2:0]  size;
        logic [1:0]  burst;
        logic [31:0] seed;
        logic [3:0]  strb;
        logic        err;
        logic [3:0]  hold;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'h3, 32'h0000_0100, 8'd3,  3'd2, 2'b01, 32'hA000_0000, 4'hF, 1'b0, 4'd0},
        '{1'b0, 4'h5, 32'h0000_0100, 8'd3,  3'd2, 2'b01, 32'h0,         4'h0, 1'b0, 4'd0},
        '{1'b1, 4'h1, 32'h0000_0200, 8'd0,  3'd2, 2'b01, 32'h1122_3344, 4'hF, 1'b0, 4'd0},
        '{1'b1, 4'h2, 32'h0000_0200, 8'd2,  3'd2, 2'b00, 32'h5566_7700, 4'h5, 1'b0, 4'd0},
        '{1'b0, 4'h6, 32'h0000_0200, 8'd1,  3'd2, 2'b00, 32'h0,         4'h0, 1'b0, 4'd3},
        '{1'b1, 4'h4, 32'h0000_0300, 8'd3,  3'd1, 2'b01, 32'hCAFE_0000, 4'hF, 1'b0, 4'd0},
        '{1'b0, 4'h7, 32'h0000_0300, 8'd1,  3'd2, 2'b01, 32'h0,         4'h0, 1'b0, 4'd0},
        '{1'b1, 4'h8, 32'h0000_0400, 8'd0,  3'd2, 2'b01, 32'h0BAD_F00D, 4'hF, 1'b0, 4'd0},
        '{1'b1, 4'h9, 32'h0000_0400, 8'd1,  3'd2, 2'b10, 32'hDEAD_0000, 4'hF, 1'b1, 4'd0},
        '{1'b0, 4'h9, 32'h0000_0400, 8'd0,  3'd2, 2'b01, 32'h0,         4'h0, 1'b0, 4'd0},
        '{1'b1, 4'hA, 32'h0000_2400, 8'd0,  3'd2, 2'b01, 32'hFEED_0000, 4'hF, 1'b1, 4'd0},
        '{1'b0, 4'hB, 32'h0000_1000, 8'd1,  3'd2, 2'b01, 32'h0,         4'h0, 1'b1, 4'd2},
        '{1'b0, 4'hC, 32'h0000_0100, 8'd0,  3'd3, 2'b01, 32'h0,         4'h0, 1'b1, 4'd0},
        '{1'b1, 4'hD, 32'h0000_0FFC, 8'd1,  3'd2, 2'b01, 32'h7777_0000, 4'hF, 1'b0, 4'd0},
        '{1'b0, 4'hE, 32'h0000_0FFC, 8'd1,  3'd2, 2'b01, 32'h0,         4'h0, 1'b0, 4'd0},
        '{1'b1, 4'hF, 32'h0000_0500, 8'd15, 3'd2, 2'b01, 32'h0000_1000, 4'hF, 1'b0, 4'd0},
        '{1'b0, 4'h0, 32'h0000_0500, 8'd15, 3'd2, 2'b01, 32'h0,         4'h0, 1'b0, 4'd2},
        '{1'b0, 4'h1, 32'h0000_0400, 8'd0,  3'd2, 2'b11, 32'h0,         4'h0, 1'b1, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        awvalid = 1'b0, wvalid = 1'b0, wlast = 1'b0, bready = 1'b0;
    logic        arvalid = 1'b0, rready = 1'b0;
    logic [3:0]  awid = '0, arid = '0, wstrb = '0;
    logic [31:0] awaddr = '0, araddr = '0, wdata = '0;
    logic [7:0]  awlen = '0, arlen = '0;
    logic [2:0]  awsize = '0, arsize = '0;
    logic [1:0]  awburst = '0, arburst = '0;
    logic        awready, wready, bvalid, arready, rvalid, rlast;
    logic [3:0]  bid, rid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] shadow [4096];

    always #2 clk = ~clk;

    axi_burst_mem u_dut (
        .clk(clk), .rst_n(rst_n),
        .awvalid(awvalid), .awready(awready), .awid(awid), .awaddr(awaddr),
        .awlen(awlen), .awsize(awsize), .awburst(awburst),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
        .bvalid(bvalid), .bready(bready), .bid(bid), .bresp(bresp),
        .arvalid(arvalid), .arready(arready), .arid(arid), .araddr(araddr),
        .arlen(arlen), .arsize(arsize), .arburst(arburst),
        .rvalid(rvalid), .rready(rready), .rid(rid), .rdata(rdata),
        .rresp(rresp), .rlast(rlast)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (ok !== 1'b1) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [31:0] step(input logic [31:0] a, input logic [1:0] b,
                                         input logic [2:0] s);
        logic [31:0] sb;
        sb = 32'd1 << s;
        if (b == 2'b00) return a;
        return (a & ~(sb - 32'd1)) + sb;
    endfunction

    function automatic logic [31:0] shadow_word(input logic [31:0] a);
        return {shadow[{a[11:2], 2'd3}], shadow[{a[11:2], 2'd2}],
                shadow[{a[11:2], 2'd1}], shadow[{a[11:2], 2'd0}]};
    endfunction

    task automatic send_aw(input logic [3:0] id, input logic [31:0] a, input logic [7:0] len,
                           input logic [2:0] sz, input logic [1:0] bt);
        @(negedge clk);
        awid = id; awaddr = a; awlen = len; awsize = sz; awburst = bt; awvalid = 1'b1;
        while (!awready) @(negedge clk);
        @(negedge clk);
        awvalid = 1'b0;
        chk(!awready, "R7", "awready after accept", {31'd0, awready}, 32'd0);
    endtask

    task automatic send_w(input logic [31:0] a0, input logic [7:0] len, input logic [2:0] sz,
                          input logic [1:0] bt, input logic [31:0] seed, input logic [3:0] st,
                          input logic err);
        logic [31:0] a;
        a = a0;
        for (int b = 0; b <= int'(len); b++) begin
            wdata = seed + 32'(b); wstrb = st; wlast = (b == int'(len)); wvalid = 1'b1;
            while (!wready) @(negedge clk);
            chk(!bvalid, "R4", "bvalid during data", {31'd0, bvalid}, 32'd0);
            if (!err) begin
                for (int l = 0; l < 4; l++)
                    if (st[l]) shadow[{a[11:2], 2'(l)}] = wdata[l*8 +: 8];
            end
            a = step(a, bt, sz);
            @(negedge clk);
        end
        wvalid = 1'b0; wlast = 1'b0;
        chk(bvalid, "R4", "bvalid after wlast", {31'd0, bvalid}, 32'd1);
    endtask

    task automatic wait_b(input logic [3:0] id, input logic err);
        bready = 1'b1;
        while (!bvalid) @(negedge clk);
        chk(bid == id, "R5", "bid", {28'd0, bid}, {28'd0, id});
        chk(bresp == (err ? 2'b10 : 2'b00), "R6", "bresp", {30'd0, bresp},
            err ? 32'd2 : 32'd0);
        @(negedge clk);
        bready = 1'b0;
        chk(awready && !bvalid, "R7", "write side reopened", {31'd0, awready}, 32'd1);
    endtask

    task automatic do_read(input logic [3:0] id, input logic [31:0] a0, input logic [7:0] len,
                           input logic [2:0] sz, input logic [1:0] bt, input logic err,
                           input logic [3:0] hold, input string tag);
        logic [31:0] a, expv, snap;
        @(negedge clk);
        arid = id; araddr = a0; arlen = len; arsize = sz; arburst = bt; arvalid = 1'b1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        chk(!arready, "R7", "arready after accept", {31'd0, arready}, 32'd0);
        a = a0;
        for (int b = 0; b <= int'(len); b++) begin
            while (!rvalid) @(negedge clk);
            if (b == 0 && hold != 4'd0) begin
                snap = rdata;
                repeat (int'(hold)) @(negedge clk);
                chk(rvalid && rdata === snap, "R10", "rdata held", rdata, snap);
            end
            expv = err ? 32'd0 : shadow_word(a);
            chk(rdata === expv, tag, "rdata", rdata, expv);
            chk(rid == id, "R5", "rid", {28'd0, rid}, {28'd0, id});
            chk(rresp == (err ? 2'b10 : 2'b00), "R6", "rresp", {30'd0, rresp},
                err ? 32'd2 : 32'd0);
            chk(rlast == (b == int'(len)), "R4", "rlast", {31'd0, rlast},
                {31'd0, (b == int'(len))});
            rready = 1'b1;
            @(negedge clk);
            rready = 1'b0;
            a = step(a, bt, sz);
        end
        chk(!rvalid && arready, "R4", "rvalid after last", {31'd0, rvalid}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        summary();
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(awready && arready && !bvalid && !rvalid, "R1", "idle after reset",
            {28'd0, awready, arready, bvalid, rvalid}, 32'hC);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            if (v.wr) begin
                send_aw(v.id, v.addr, v.len, v.size, v.burst);
                send_w(v.addr, v.len, v.size, v.burst, v.seed, v.strb, v.err);
                wait_b(v.id, v.err);
            end else begin
                // R2 strobed fixed area, R9 wrap past the end, R3 plain bursts
                if (v.err)                     tag = "R6";
                else if (v.addr == 32'hFFC)    tag = "R9";
                else if (v.burst == 2'b00)     tag = "R2";
                else                           tag = "R3";
                do_read(v.id, v.addr, v.len, v.size, v.burst, v.err, v.hold, tag);
            end
        end

        // R8: read burst served while write waits for its data
        send_aw(4'h2, 32'h600, 8'd1, 3'd2, 2'b01);
        do_read(4'h3, 32'h100, 8'd1, 3'd2, 2'b01, 1'b0, 4'd0, "R8");
        chk(!awready && !bvalid, "R8", "write still open", {31'd0, awready}, 32'd0);
        send_w(32'h600, 8'd1, 3'd2, 2'b01, 32'h6060_0000, 4'hF, 1'b0);
        wait_b(4'h2, 1'b0);
        do_read(4'h4, 32'h600, 8'd1, 3'd2, 2'b01, 1'b0, 4'd0, "R8");

        // R10: write response held under backpressure
        send_aw(4'h6, 32'h700, 8'd0, 3'd2, 2'b01);
        send_w(32'h700, 8'd0, 3'd2, 2'b01, 32'h7070_7070, 4'hF, 1'b0);
        repeat (3) @(negedge clk);
        chk(bvalid && bid == 4'h6 && bresp == 2'b00, "R10", "b held",
            {28'd0, bid}, 32'h6);
        wait_b(4'h6, 1'b0);

        summary();
    end

endmodule